// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shut-off

This block is a watchdog timer. Software reaches it through one byte-wide control register on a simple synchronous register bus: a write strobe, a write byte and a combinational read byte. The register holds a run bit, a three-bit timeout select and a short-lived unlock bit. While the watchdog runs, its counter advances on each cycle in which the tick-enable input is high. When the selected number of ticks has gone by, the block raises a reset request for one clock and starts the next period from zero. A restart strobe clears the counter, and software pulses it to prove it is still alive.

A single stray write must not be able to stop the watchdog. Setting the run bit always works. Clearing it is honoured only while the unlock bit is set. Software sets the unlock bit, together with the run bit, in one write. Hardware then drops the unlock bit by itself four clocks later, so the write that clears the run bit has to land inside that short window.

Top module: `wdog_guarded`

## Requirements
- R1: After reset the control register reads 0x00 and the reset request is low.
- R2: Bits 7..5 of the register always read zero, and writes to them are ignored.
- R3: Field layout: bit 4 is the unlock bit, bit 3 is the run bit and bits 2..0 are the timeout select. Every write loads the timeout select, and the value written is read back unchanged.
- R4: A write with bit 4 set makes the unlock bit read 1 for the next four clocks. Hardware then clears it with no write needed. Writing 0 to bit 4 does not clear it early.
- R5: A write with bit 3 at 0 while the unlock bit reads 0 leaves the run bit at its old value.
- R6: A write with bit 3 at 0 while the unlock bit reads 1 clears the run bit. A write made after the four-clock window has closed does not clear it.
- R7: A write with bit 3 at 1 always sets the run bit, whatever the state of the unlock bit.
- R8: With the run bit set, the reset request goes high for exactly one clock after 2^(BASE_LOG2+sel) counted ticks. With the default BASE_LOG2 of 14, select 0 through 7 gives 16K through 2048K ticks, with K = 1024. The count then starts again from zero.
- R9: The counter advances only in cycles where the run bit is set and tick_en is high. Otherwise it holds its value, including while the watchdog is stopped.
- R10: The restart strobe clears the counter, and it takes priority over a tick in the same cycle.
- R11: Changing the timeout select does not clear the counter. If the count is already at or past the new limit, the next counted tick raises the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tick_en | input | 1 | Watchdog tick enable |
| restart | input | 1 | Clear the counter (keep-alive) |
| reset_req | output | 1 | One-clock reset request on timeout |

## Verification
The hardest situations to reach are a counter value that survives a shut-off and a count that is already beyond a newly lowered limit. The stimulus stops the watchdog through the full unlock sequence after 31 counted ticks and keeps ticking while it is stopped. It then restarts the watchdog and shows that one more tick completes the period. For the lowered limit, the bench counts 20 ticks under select 1 and then switches to select 0. A cycle-accurate behavioural model checks the register byte and the request on every clock, including the exact clock on which the unlock window closes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int SEL_W     = 3;
    localparam int UNLOCK_B  = 4;
    localparam int RUN_B     = 3;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic unlock;
        logic run;
        sel_t sel;
    } ctrl_view_t;

    function automatic logic [7:0] pack_view(input ctrl_view_t v);
        logic [7:0] b;
        b = 8'h00;
        b[UNLOCK_B]      = v.unlock;
        b[RUN_B]         = v.run;
        b[SEL_W-1:0]     = v.sel;
        return b;
    endfunction
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctrl_view_t view
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    typedef struct packed {
        logic             run;
        sel_t             sel;
        logic [WIN_W-1:0] win;
    } state_t;

    state_t s_d, s_q;
    logic   open_q;

    assign open_q = (s_q.win != '0);

    always_comb begin
        s_d = s_q;
        if (s_q.win != '0) begin
            s_d.win = s_q.win - WIN_W'(1);
        end
        if (we) begin
            s_d.sel = wdata[SEL_W-1:0];
            if (wdata[RUN_B]) begin
                s_d.run = 1'b1;
            end else if (open_q) begin
                s_d.run = 1'b0;
            end
            if (wdata[UNLOCK_B]) begin
                s_d.win = WIN_W'(WINDOW);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign view.unlock = open_q;
    assign view.run    = s_q.run;
    assign view.sel    = s_q.sel;

    assert_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.run) |-> $past(open_q));

    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[RUN_B]) |=> s_q.run);

    assert_unlock_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_q) |-> !$past(we && wdata[UNLOCK_B]));

    assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (s_q.sel == $past(wdata[SEL_W-1:0])));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  sel_t sel,
    input  logic tick_en,
    input  logic restart,
    output logic bark
);
    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int CNT_W   = BASE_LOG2 + MAX_SEL + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bark;
    } state_t;

    state_t           s_d, s_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] next_cnt;

    assign limit    = CNT_W'(1) << (BASE_LOG2 + int'(sel));
    assign next_cnt = s_q.cnt + CNT_W'(1);

    always_comb begin
        s_d      = s_q;
        s_d.bark = 1'b0;
        if (restart) begin
            s_d.cnt = '0;
        end else if (run && tick_en) begin
            if (next_cnt >= limit) begin
                s_d.cnt  = '0;
                s_d.bark = 1'b1;
            end else begin
                s_d.cnt = next_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bark = s_q.bark;

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bark |=> !s_q.bark);

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bark |-> (s_q.cnt == '0));

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0 && !s_q.bark));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(run && tick_en)) |=> ($stable(s_q.cnt) && !s_q.bark));
endmodule

// File: rtl/wdog_guarded.sv
module wdog_guarded
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int WINDOW    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tick_en,
    input  logic       restart,
    output logic       reset_req
);
    ctrl_view_t view;

    wdog_ctrl_reg #(.WINDOW(WINDOW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .view  (view)
    );

    wdog_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (view.run),
        .sel     (view.sel),
        .tick_en (tick_en),
        .restart (restart),
        .bark    (reset_req)
    );

    assign reg_rdata = pack_view(view);

    assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:5] == 3'b000);

    assert_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 8'h00 && !reset_req));
endmodule

// File: tb/wdog_guarded_tb.sv
module wdog_guarded_tb;
    localparam int B = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tick_en = 1'b0;
    logic       restart = 1'b0;
    logic       reset_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    string tag = "R1";

    // behavioural reference
    int m_run = 0, m_sel = 0, m_win = 0, m_cnt = 0, m_req = 0;

    always #5 clk = ~clk;

    wdog_guarded #(.BASE_LOG2(B), .WINDOW(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tick_en(tick_en), .restart(restart),
        .reset_req(reset_req)
    );

    function automatic int exp_rd();
        return ((m_win > 0) ? 16 : 0) + m_run * 8 + m_sel;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called just after a negedge
    task automatic step(input bit we, input int wd, input bit rs, input bit tk);
        int lim;
        check(int'(reg_rdata) == exp_rd(), {tag, " rdata"}, reg_rdata, exp_rd());
        check(int'(reset_req) == m_req, {tag, " reset_req"}, reset_req, m_req);
        reg_we = we; reg_wdata = 8'(wd); restart = rs; tick_en = tk;
        @(posedge clk);
        lim = 1 << (B + m_sel);
        m_req = 0;
        if (rs) m_cnt = 0;
        else if (m_run != 0 && tk) begin
            if (m_cnt + 1 >= lim) begin m_cnt = 0; m_req = 1; end
            else m_cnt++;
        end
        if (m_win > 0) m_win--;
        if (we) begin
            if (wd[3]) m_run = 1;
            else if (m_win > 0 || (m_win == 0 && win_was_open)) m_run = 0;
            m_sel = wd & 7;
            if (wd[4]) m_win = 4;
        end
        @(negedge clk);
        if (reset_req) pulses++;
        reg_we = 1'b0; restart = 1'b0; tick_en = 1'b0;
    endtask

    bit win_was_open = 1'b0;
    always @(negedge clk) win_was_open = (m_win > 0);

    task automatic wr(input int v);   step(1'b1, v, 1'b0, 1'b0); endtask
    task automatic idle(input int n); for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0); endtask
    task automatic ticks(input int n); for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b1); endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check(reg_rdata == 8'h00 && !reset_req, "R1 reset state", reg_rdata, 0);

        tag = "R2";
        wr(8'hFF);
        check(reg_rdata == 8'h1F, "R2 R3 reserved zero, fields loaded", reg_rdata, 8'h1F);
        tag = "R4";
        step(1'b1, 8'h0F, 1'b0, 1'b0);
        idle(2);
        check(reg_rdata[4] == 1'b1, "R4 unlock held within window", reg_rdata[4], 1);
        idle(1);
        check(reg_rdata[4] == 1'b0, "R4 unlock self-cleared", reg_rdata[4], 0);

        tag = "R5";
        wr(8'h00);
        check(reg_rdata == 8'h08, "R5 locked clear ignored", reg_rdata, 8'h08);

        tag = "R6";
        wr(8'h18);
        idle(2);
        wr(8'h02);
        check(reg_rdata == 8'h12, "R6 clear inside window", reg_rdata, 8'h12);
        idle(4);
        tag = "R7";
        wr(8'h08);
        check(reg_rdata[3] == 1'b1, "R7 set always allowed", reg_rdata[3], 1);
        tag = "R6";
        wr(8'h18);
        idle(4);
        wr(8'h00);
        check(reg_rdata == 8'h08, "R6 clear after window ignored", reg_rdata, 8'h08);

        tag = "R8";
        wr(8'h08);
        step(1'b0, 0, 1'b1, 1'b0);
        pulses = 0;
        ticks(15);
        check(pulses == 0, "R8 no early request", pulses, 0);
        ticks(1);
        check(reset_req == 1'b1, "R8 request at limit", reset_req, 1);
        ticks(1);
        check(reset_req == 1'b0, "R8 request one clock", reset_req, 0);
        ticks(47);
        check(pulses == 4, "R8 periodic wrap count", pulses, 4);

        tag = "R9";
        wr(8'h09);
        step(1'b0, 0, 1'b1, 1'b0);
        pulses = 0;
        for (int i = 0; i < 62; i++) step(1'b0, 0, 1'b0, i[0]);
        wr(8'h19);
        wr(8'h01);
        ticks(100);
        check(pulses == 0, "R9 no count while stopped", pulses, 0);
        wr(8'h09);
        ticks(1);
        check(reset_req == 1'b1, "R9 count held across stop", reset_req, 1);

        tag = "R10";
        step(1'b0, 0, 1'b1, 1'b0);
        pulses = 0;
        ticks(31);
        step(1'b0, 0, 1'b1, 1'b1);
        ticks(31);
        check(pulses == 0, "R10 restart beats tick", pulses, 0);
        ticks(1);
        check(reset_req == 1'b1, "R10 full period after restart", reset_req, 1);

        tag = "R11";
        step(1'b0, 0, 1'b1, 1'b0);
        ticks(20);
        wr(8'h08);
        pulses = 0;
        ticks(1);
        check(reset_req == 1'b1, "R11 lowered limit fires next tick", reset_req, 1);

        tag = "R8";
        wr(8'h0F);
        step(1'b0, 0, 1'b1, 1'b0);
        pulses = 0;
        ticks(2047);
        check(pulses == 0, "R8 select 7 no early request", pulses, 0);
        ticks(1);
        check(reset_req == 1'b1, "R8 select 7 limit", reset_req, 1);
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule